// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Paired Result Registers

This unit computes 32x32 products and 32/32 quotients over many clock cycles and keeps the outcome in a pair of dedicated result registers, HI and LO. It does not write a general register. A core issues a start command with two operands and a choice between signed and unsigned arithmetic. The unit then raises `busy` while it iterates one bit per cycle. A multiply leaves the 64-bit product split across HI (upper half) and LO (lower half). A divide leaves the quotient in LO and the remainder in HI.

Separate move commands let the core read HI or LO, or load either one from a register operand. The read path is interlocked. A read issued while an operation is still running raises `stall` instead of returning data, and the core holds the command until `stall` drops. A start that arrives while the unit is busy discards the running operation and begins the new one. No form of the command takes an immediate operand.

Top module: `muldivUnit`

## Requirements
- R1: A command is taken on a rising clock edge when `cmdValid` is high. The `cmdOp` codes are: 0 signed multiply, 1 unsigned multiply, 2 signed divide, 3 unsigned divide, 4 read HI, 5 read LO, 6 write HI from `opA`, 7 write LO from `opA`. A signed multiply leaves the two's-complement 64-bit product of `opA` and `opB`, with the upper 32 bits in HI and the lower 32 bits in LO.
- R2: An unsigned multiply treats both operands as unsigned and leaves the 64-bit product split the same way.
- R3: A signed divide truncates the quotient toward zero and writes it to LO. It writes the remainder to HI, and the remainder carries the sign of the dividend. The most negative value divided by -1 gives a quotient of 0x80000000 and a remainder of 0.
- R4: An unsigned divide treats both operands as unsigned, writing the quotient to LO and the remainder to HI.
- R5: A divide by zero, signed or unsigned, completes in the normal time and leaves LO all ones and HI equal to the dividend.
- R6: `busy` is high in the 33 cycles that follow the edge accepting a start. The results appear in HI/LO at the 33rd edge, and `busy` is low after that edge.
- R7: A read command issued while `busy` is low returns HI (code 4) or LO (code 5) on `rdData` in the same cycle, with `rdValid` high and `stall` low.
- R8: A read command issued while `busy` is high drives `stall` high and `rdValid` low. A read that is held on the command lines returns the new result in the first cycle after `busy` falls.
- R9: A write command loads only the selected register from `opA`, and the other register keeps its value.
- R10: A start that arrives while `busy` is high aborts the running operation. Its results are never written, and the new operation takes the full 33 cycles from its own start.
- R11: A write command that arrives while `busy` is high cancels the running operation, so `busy` is low after that edge. It loads the selected register, and the other register keeps the value it held before the cancelled operation.
- R12: After reset, HI and LO are zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Command code (see R1) |
| opA | input | 32 | Multiplicand / dividend, or value for a register write |
| opB | input | 32 | Multiplier / divisor |
| rdData | output | 32 | HI or LO as selected by a read command |
| rdValid | output | 1 | A read command is returning data this cycle |
| busy | output | 1 | An operation is in progress |
| stall | output | 1 | A read command must be held because the unit is busy |

## Verification
The embedded properties check four things on every cycle:
- a start always leaves the unit busy at the next edge;
- a write command always leaves it idle;
- the final fix-up cycle always ends the operation;
- HI and LO never change except through a finish or a write strobe.

They also confirm the all-ones quotient after a divide by zero. Only the bench's scenarios show that the arithmetic is right. Those scenarios cover signs, extreme operands, rounding of signed quotients, abort by a second start, cancel by a write, and the exact cycle in which a held read is released. A behavioural model in the bench tracks the expected `busy` and the expected register contents on every clock.

// File: rtl/muldivPkg.sv
package muldivPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } ctrlState_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic load;    // capture operands, begin an operation
    logic step;    // one iteration
    logic finish;  // sign fix-up and result write
    logic setHi;   // write HI from opA
    logic setLo;   // write LO from opA
  } mdStrobe_t;

endpackage

// File: rtl/muldivControl.sv
module muldivControl
  import muldivPkg::*;
#(
  parameter int W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  output mdStrobe_t  st,
  output logic       busy
);

  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [IW-1:0] LAST = IW'(W - 1);

  ctrlState_t state;
  logic [IW-1:0] iter;
  logic isStart, isMove;

  assign isStart = cmdValid && !cmdOp[2];
  assign isMove  = cmdValid && cmdOp[2] && cmdOp[1];
  assign busy    = (state != ST_IDLE);

  always_comb begin
    st        = '0;
    st.load   = isStart;
    st.setHi  = isMove && !cmdOp[0];
    st.setLo  = isMove && cmdOp[0];
    st.step   = (state == ST_RUN) && !isStart && !isMove;
    st.finish = (state == ST_FIX) && !isStart && !isMove;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      iter  <= '0;
    end else if (isStart) begin
      state <= ST_RUN;
      iter  <= '0;
    end else if (isMove) begin
      state <= ST_IDLE;
      iter  <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (iter == LAST) state <= ST_FIX;
          iter <= iter + 1'b1;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: an accepted start leaves the unit busy at the next edge
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    st.load |=> busy);

  // R10: a start, even while busy, restarts the iteration from zero
  a_r10_restart: assert property (@(posedge clk) disable iff (!rstN)
    st.load |=> (state == ST_RUN && iter == '0));

  // R11: a register write always leaves the unit idle
  a_r11_move_cancels: assert property (@(posedge clk) disable iff (!rstN)
    isMove |=> !busy);

  // R6: the fix-up cycle ends the operation
  a_r6_fix_ends: assert property (@(posedge clk) disable iff (!rstN)
    st.finish |=> !busy);

endmodule

// File: rtl/muldivDatapath.sv
module muldivDatapath
  import muldivPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdStrobe_t    st,
  input  logic [1:0]   opKind,   // [1] divide, [0] unsigned
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] hiOut,
  output logic [W-1:0] loOut
);

  logic [W-1:0] hiReg, loReg;
  logic [W-1:0] accHi, accLo, mcand;
  logic         isDiv, negRes, negRem, divZero;

  // Operand magnitudes for the signed forms
  logic         aNeg, bNeg;
  logic [W-1:0] aMag, bMag;
  assign aNeg = !opKind[0] && opA[W-1];
  assign bNeg = !opKind[0] && opB[W-1];
  assign aMag = aNeg ? (~opA + 1'b1) : opA;
  assign bMag = bNeg ? (~opB + 1'b1) : opB;

  // One shift-add multiply step
  logic [W:0] mulSum;
  assign mulSum = {1'b0, accHi} + (accLo[0] ? {1'b0, mcand} : '0);

  // One restoring divide step
  logic [W:0] divShift, divDiff;
  assign divShift = {accHi, accLo[W-1]};
  assign divDiff  = divShift - {1'b0, mcand};

  // Sign fix-up
  logic [2*W-1:0] prodMag, prodFix;
  logic [W-1:0]   quoFix, remFix;
  assign prodMag = {accHi, accLo};
  assign prodFix = negRes ? (~prodMag + 1'b1) : prodMag;
  assign quoFix  = divZero ? '1 : (negRes ? (~accLo + 1'b1) : accLo);
  assign remFix  = negRem ? (~accHi + 1'b1) : accHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg   <= '0;
      loReg   <= '0;
      accHi   <= '0;
      accLo   <= '0;
      mcand   <= '0;
      isDiv   <= 1'b0;
      negRes  <= 1'b0;
      negRem  <= 1'b0;
      divZero <= 1'b0;
    end else begin
      if (st.load) begin
        isDiv   <= opKind[1];
        negRes  <= aNeg ^ bNeg;
        negRem  <= aNeg;
        divZero <= (opB == '0);
        accHi   <= '0;
        accLo   <= opKind[1] ? aMag : bMag;
        mcand   <= opKind[1] ? bMag : aMag;
      end else if (st.step) begin
        if (isDiv) begin
          accHi <= divDiff[W] ? divShift[W-1:0] : divDiff[W-1:0];
          accLo <= {accLo[W-2:0], !divDiff[W]};
        end else begin
          accHi <= mulSum[W:1];
          accLo <= {mulSum[0], accLo[W-1:1]};
        end
      end
      if (st.finish) begin
        if (isDiv) begin
          hiReg <= remFix;
          loReg <= quoFix;
        end else begin
          hiReg <= prodFix[2*W-1:W];
          loReg <= prodFix[W-1:0];
        end
      end
      if (st.setHi) hiReg <= opA;
      if (st.setLo) loReg <= opA;
    end
  end

  assign hiOut = hiReg;
  assign loOut = loReg;

  // R9: HI changes only through a finish or its own write strobe
  a_r9_hi_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!st.finish && !st.setHi) |=> $stable(hiReg));

  // R9: LO changes only through a finish or its own write strobe
  a_r9_lo_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!st.finish && !st.setLo) |=> $stable(loReg));

  // R5: a divide by zero leaves LO all ones
  a_r5_divzero_lo: assert property (@(posedge clk) disable iff (!rstN)
    (st.finish && isDiv && divZero) |=> (loReg == '1));

endmodule

// File: rtl/muldivUnit.sv
module muldivUnit
  import muldivPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic [31:0] rdData,
  output logic        rdValid,
  output logic        busy,
  output logic        stall
);

  localparam int W = 32;

  mdStrobe_t st;
  logic [W-1:0] hiVal, loVal;
  logic isRead;

  muldivControl #(.W(W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .st(st), .busy(busy)
  );

  muldivDatapath #(.W(W)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .opKind(cmdOp[1:0]),
    .opA(opA), .opB(opB), .hiOut(hiVal), .loOut(loVal)
  );

  assign isRead  = cmdValid && cmdOp[2] && !cmdOp[1];
  assign rdData  = cmdOp[0] ? loVal : hiVal;
  assign rdValid = isRead && !busy;
  assign stall   = isRead && busy;

endmodule

// File: tb/test_muldivUnit.sv
`timescale 1ns/1ps
module test_muldivUnit;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [31:0] rdData;
  logic rdValid, busy, stall;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  muldivUnit i_muldivUnit (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .opA(opA), .opB(opB), .rdData(rdData), .rdValid(rdValid),
    .busy(busy), .stall(stall)
  );

  // Behavioural reference model
  logic [31:0] mHi, mLo, pHi, pLo;
  int mCnt;

  task automatic calc(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                      output logic [31:0] hi, output logic [31:0] lo);
    longint sa, sb, q, r;
    logic [63:0] p;
    if (op[0]) begin sa = longint'({32'b0, a}); sb = longint'({32'b0, b}); end
    else begin sa = longint'($signed(a)); sb = longint'($signed(b)); end
    if (!op[1]) begin
      p = 64'(sa * sb);
      hi = p[63:32]; lo = p[31:0];
    end else if (b == 0) begin
      hi = a; lo = 32'hFFFF_FFFF;
    end else begin
      q = sa / sb; r = sa % sb;
      lo = q[31:0]; hi = r[31:0];
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mHi = 0; mLo = 0; mCnt = 0;
    end else if (cmdValid && !cmdOp[2]) begin
      calc(cmdOp, opA, opB, pHi, pLo);
      mCnt = 33;
    end else if (cmdValid && cmdOp[2:1] == 2'b11) begin
      mCnt = 0;
      if (cmdOp[0]) mLo = opA; else mHi = opA;
    end else if (mCnt > 0) begin
      mCnt = mCnt - 1;
      if (mCnt == 0) begin mHi = pHi; mLo = pLo; end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle's command at the falling edge, compare shortly after
  task automatic cyc(input logic v, input logic [2:0] op, input logic [31:0] a,
                     input logic [31:0] b, input string tag);
    @(negedge clk);
    cmdValid = v; cmdOp = op; opA = a; opB = b;
    #1;
    chk(tag, "busy", {31'b0, busy}, {31'b0, mCnt > 0});
    if (v && op[2:1] == 2'b10) begin
      if (mCnt > 0) begin
        chk(tag, "stall", {31'b0, stall}, 32'd1);
        chk(tag, "rdValid", {31'b0, rdValid}, 32'd0);
      end else begin
        chk(tag, "stall", {31'b0, stall}, 32'd0);
        chk(tag, "rdValid", {31'b0, rdValid}, 32'd1);
        chk(tag, op[0] ? "LO" : "HI", rdData, op[0] ? mLo : mHi);
      end
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 32'd0, 32'd0, tag);
  endtask

  task automatic runOp(input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    cyc(1'b1, op, a, b, tag);
    idle(33, "R6");
    cyc(1'b1, 3'd4, 32'd0, 32'd0, tag);
    cyc(1'b1, 3'd5, 32'd0, 32'd0, tag);
  endtask

  initial begin
    idle(3, "R12");
    @(negedge clk); rstN = 1'b1;
    cyc(1'b1, 3'd4, 0, 0, "R12");
    cyc(1'b1, 3'd5, 0, 0, "R12");

    runOp(3'd0, 32'hFFFF_FFFD, 32'd7, "R1");
    runOp(3'd0, 32'h8000_0000, 32'h8000_0000, "R1");
    runOp(3'd0, 32'h1234_5678, 32'hFEDC_BA98, "R1");
    runOp(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    runOp(3'd1, 32'h8000_0001, 32'd3, "R2");
    runOp(3'd2, 32'hFFFF_FFF9, 32'd2, "R3");
    runOp(3'd2, 32'd7, 32'hFFFF_FFFE, "R3");
    runOp(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R3");
    runOp(3'd3, 32'hFFFF_FFF9, 32'd2, "R4");
    runOp(3'd3, 32'd5, 32'd9, "R4");
    runOp(3'd2, 32'hFFFF_FF00, 32'd0, "R5");
    runOp(3'd3, 32'h0000_1234, 32'd0, "R5");

    // R9: each write touches only its own register
    cyc(1'b1, 3'd6, 32'hAAAA_5555, 0, "R9");
    cyc(1'b1, 3'd5, 0, 0, "R9");
    cyc(1'b1, 3'd7, 32'h0F0F_F0F0, 0, "R9");
    cyc(1'b1, 3'd4, 0, 0, "R9");
    cyc(1'b1, 3'd5, 0, 0, "R9");

    // R8: a read held while busy is released right after completion
    cyc(1'b1, 3'd0, 32'd1000, 32'd1000, "R8");
    for (int i = 0; i < 35; i++) cyc(1'b1, 3'd5, 0, 0, "R8");
    cyc(1'b1, 3'd4, 0, 0, "R8");

    // R10: a second start aborts the first
    cyc(1'b1, 3'd1, 32'hFFFF_FFFF, 32'd2, "R10");
    idle(10, "R10");
    cyc(1'b1, 3'd3, 32'd100, 32'd7, "R10");
    idle(33, "R10");
    cyc(1'b1, 3'd4, 0, 0, "R10");
    cyc(1'b1, 3'd5, 0, 0, "R10");

    // R11: a write while busy cancels the operation
    cyc(1'b1, 3'd0, 32'd12345, 32'd678, "R11");
    idle(20, "R11");
    cyc(1'b1, 3'd6, 32'hDEAD_BEEF, 0, "R11");
    idle(40, "R11");
    cyc(1'b1, 3'd4, 0, 0, "R11");
    cyc(1'b1, 3'd5, 0, 0, "R11");

    // R11: a write in the fix-up cycle also cancels
    cyc(1'b1, 3'd2, 32'd50, 32'd3, "R11");
    idle(32, "R11");
    cyc(1'b1, 3'd7, 32'h0000_0042, 0, "R11");
    idle(3, "R11");
    cyc(1'b1, 3'd4, 0, 0, "R11");
    cyc(1'b1, 3'd5, 0, 0, "R11");

    // R7: reads return data at once when idle
    cyc(1'b1, 3'd4, 0, 0, "R7");
    cyc(1'b1, 3'd5, 0, 0, "R7");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule